// File: doc/BRIEF.md
# Time-Multiplexed Multiport Register File

This block behaves as a register file with three write ports and five read ports, but it stores every entry in one dual-port memory array. It runs on a host clock that is four times the rate of the target clock the surrounding logic expects. Each target cycle is split into four host phases. A fixed schedule places the five reads and three writes on the two physical memory ports across those phases. The results match a true 3-write/5-read flop array, bit for bit and cycle for cycle.

The caller raises a one-host-cycle strobe in the last host cycle of each target cycle. The rising host edge that ends the strobe cycle is the target edge. On that edge the block captures every address, data and enable. It then runs the four phases. On the edge that ends phase 3, it loads all five read results into the output registers at once. That edge coincides with the next target edge. The read data stay constant for the whole target cycle that follows. Depth and data width are parameters. Reset clears the control state and the output registers, but not the stored entries.

Top module: `tdm_regfile`

## Requirements
- R1: Every read returns the entry as it was before the writes of its own target cycle, including when a write in that same cycle uses the same address.
- R2: When two or more enabled write ports hit one address in a target cycle, the entry takes the data of the highest-numbered enabled port (port 2 over port 1 over port 0).
- R3: A write port whose enable bit (bit i of `wr_en_i` for port i) is low changes no entry, whatever its address and data.
- R4: All five read lanes change together, only on the fourth host edge after the capture edge; between such edges `rd_data_o` holds its value.
- R5: After reset, `rd_data_o` is zero and stays zero, with no memory access, until the first strobe.
- R6: Port inputs are sampled only on the host edge that ends a strobe cycle; values presented on any other host cycle have no effect.
- R7: Data written in one target cycle is returned by reads of that address in every later target cycle until it is overwritten.
- R8: Lane r of `rd_data_o` occupies bits [r*DW +: DW] and answers read address lane r of `rd_addr_i` (bits [r*AW +: AW]); write port w uses bits [w*AW +: AW] of `wr_addr_i` and [w*DW +: DW] of `wr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock, four times the target rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tgt_strobe_i | input | 1 | One host cycle wide, high in the last host cycle of each target cycle |
| wr_en_i | input | 3 | Write enables, bit i for write port i |
| wr_addr_i | input | 3*AW | Write addresses, packed by port |
| wr_data_i | input | 3*DW | Write data, packed by port |
| rd_addr_i | input | 5*AW | Read addresses, packed by lane |
| rd_data_o | output | 5*DW | Read results, packed by lane, held for a target cycle |

## Verification
The bench builds the block with 16 entries of 16 bits. With so few entries, random addresses often collide between read and write ports and among the three write ports within one target cycle. Every entry is also rewritten many times, so stale-data and priority errors surface quickly. The narrow width keeps the per-clock comparison of all five lanes against the behavioural model cheap. It loses nothing structural, because the schedule does not depend on depth or width.

// File: rtl/tdm_rf_pkg.sv
package tdm_rf_pkg;
  localparam int NUM_RD = 5;
  localparam int NUM_WR = 3;
  localparam int NUM_PH = 4;

  typedef enum logic [1:0] {
    PH_0 = 2'd0,
    PH_1 = 2'd1,
    PH_2 = 2'd2,
    PH_3 = 2'd3
  } phase_e;
endpackage

// File: rtl/tdm_rf_seq.sv
module tdm_rf_seq
  import tdm_rf_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   strobe_i,
  output phase_e phase_o,
  output logic   active_o
);
  phase_e phase_q;
  logic   active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_0;
      active_q <= 1'b0;
    end else if (strobe_i) begin
      phase_q  <= PH_0;
      active_q <= 1'b1;
    end else if (active_q) begin
      phase_q <= phase_e'(phase_q + 2'd1);
      if (phase_q == PH_3) active_q <= 1'b0;
    end
  end

  assign phase_o  = phase_q;
  assign active_o = active_q;

  AST_STROBE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (phase_q == PH_0) && active_q); // R4

  AST_SINGLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && phase_q == PH_3 && !strobe_i) |=> !active_q); // R6
endmodule

// File: rtl/tdm_rf_slots.sv
module tdm_rf_slots
  import tdm_rf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          strobe_i,
  input  phase_e                        phase_i,
  input  logic                          active_i,
  input  logic [NUM_WR-1:0]             wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]     wr_addr_i,
  input  logic [NUM_WR-1:0][DW-1:0]     wr_data_i,
  input  logic [NUM_RD-1:0][AW-1:0]     rd_addr_i,
  output logic                          a_en_o,
  output logic                          a_we_o,
  output logic [AW-1:0]                 a_addr_o,
  output logic [DW-1:0]                 a_wdata_o,
  output logic                          b_en_o,
  output logic                          b_we_o,
  output logic [AW-1:0]                 b_addr_o,
  output logic [DW-1:0]                 b_wdata_o
);
  logic [NUM_WR-1:0]         wen_q;
  logic [NUM_WR-1:0][AW-1:0] wa_q;
  logic [NUM_WR-1:0][DW-1:0] wd_q;
  logic [NUM_RD-1:0][AW-1:0] ra_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q <= '0;
      wa_q  <= '0;
      wd_q  <= '0;
      ra_q  <= '0;
    end else if (strobe_i) begin
      wen_q <= wr_en_i;
      wa_q  <= wr_addr_i;
      wd_q  <= wr_data_i;
      ra_q  <= rd_addr_i;
    end
  end

  // reads in phases 0-2, writes in 2-3; port 2 is last so it wins
  always_comb begin
    a_en_o    = 1'b0;
    a_we_o    = 1'b0;
    a_addr_o  = '0;
    a_wdata_o = '0;
    b_en_o    = 1'b0;
    b_we_o    = 1'b0;
    b_addr_o  = '0;
    b_wdata_o = '0;
    unique case (phase_i)
      PH_0: begin
        a_en_o = active_i; a_addr_o = ra_q[0];
        b_en_o = active_i; b_addr_o = ra_q[1];
      end
      PH_1: begin
        a_en_o = active_i; a_addr_o = ra_q[2];
        b_en_o = active_i; b_addr_o = ra_q[3];
      end
      PH_2: begin
        a_en_o = active_i; a_addr_o = ra_q[4];
        b_we_o = active_i & wen_q[0]; b_addr_o = wa_q[0]; b_wdata_o = wd_q[0];
      end
      PH_3: begin
        a_we_o = active_i & wen_q[1]; a_addr_o = wa_q[1]; a_wdata_o = wd_q[1];
        b_we_o = active_i & wen_q[2]; b_addr_o = wa_q[2]; b_wdata_o = wd_q[2];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tdm_rf_dpram.sv
module tdm_rf_dpram #(
  parameter int DEPTH = 32,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read-first on both ports; b write lands after a write
  always_ff @(posedge clk_i) begin
    if (a_en_i) a_rdata_o <= mem_q[a_addr_i];
    if (b_en_i) b_rdata_o <= mem_q[b_addr_i];
    if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
  end
endmodule

// File: rtl/tdm_rf_collect.sv
module tdm_rf_collect
  import tdm_rf_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  phase_e                    phase_i,
  input  logic                      active_i,
  input  logic [DW-1:0]             a_rdata_i,
  input  logic [DW-1:0]             b_rdata_i,
  output logic [NUM_RD-1:0][DW-1:0] rd_data_o
);
  logic [NUM_RD-2:0][DW-1:0] stage_q;
  logic                      commit;

  assign commit = active_i && (phase_i == PH_3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= '0;
      rd_data_o <= '0;
    end else if (active_i) begin
      if (phase_i == PH_1) begin
        stage_q[0] <= a_rdata_i;
        stage_q[1] <= b_rdata_i;
      end
      if (phase_i == PH_2) begin
        stage_q[2] <= a_rdata_i;
        stage_q[3] <= b_rdata_i;
      end
      if (commit) rd_data_o <= {a_rdata_i, stage_q};
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(rd_data_o)); // R4
endmodule

// File: rtl/tdm_regfile.sv
module tdm_regfile
  import tdm_rf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tgt_strobe_i,
  input  logic [NUM_WR-1:0]    wr_en_i,
  input  logic [NUM_WR*AW-1:0] wr_addr_i,
  input  logic [NUM_WR*DW-1:0] wr_data_i,
  input  logic [NUM_RD*AW-1:0] rd_addr_i,
  output logic [NUM_RD*DW-1:0] rd_data_o
);
  phase_e                    phase;
  logic                      active;
  logic [NUM_WR-1:0][AW-1:0] wa;
  logic [NUM_WR-1:0][DW-1:0] wd;
  logic [NUM_RD-1:0][AW-1:0] ra;
  logic [NUM_RD-1:0][DW-1:0] rd;
  logic                      a_en, a_we, b_en, b_we;
  logic [AW-1:0]             a_addr, b_addr;
  logic [DW-1:0]             a_wdata, b_wdata, a_rdata, b_rdata;

  assign wa        = wr_addr_i;
  assign wd        = wr_data_i;
  assign ra        = rd_addr_i;
  assign rd_data_o = rd;

  tdm_rf_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (tgt_strobe_i),
    .phase_o  (phase),
    .active_o (active)
  );

  tdm_rf_slots #(.DEPTH(DEPTH), .DW(DW)) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_i  (tgt_strobe_i),
    .phase_i   (phase),
    .active_i  (active),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wa),
    .wr_data_i (wd),
    .rd_addr_i (ra),
    .a_en_o    (a_en),
    .a_we_o    (a_we),
    .a_addr_o  (a_addr),
    .a_wdata_o (a_wdata),
    .b_en_o    (b_en),
    .b_we_o    (b_we),
    .b_addr_o  (b_addr),
    .b_wdata_o (b_wdata)
  );

  tdm_rf_dpram #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i     (clk_i),
    .a_en_i    (a_en),
    .a_we_i    (a_we),
    .a_addr_i  (a_addr),
    .a_wdata_i (a_wdata),
    .a_rdata_o (a_rdata),
    .b_en_i    (b_en),
    .b_we_i    (b_we),
    .b_addr_i  (b_addr),
    .b_wdata_i (b_wdata),
    .b_rdata_o (b_rdata)
  );

  tdm_rf_collect #(.DW(DW)) u_collect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .active_i  (active),
    .a_rdata_i (a_rdata),
    .b_rdata_i (b_rdata),
    .rd_data_o (rd)
  );

  AST_WRITES_AFTER_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_we || b_we) |-> (phase == PH_2 || phase == PH_3)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !(a_en || b_en || a_we || b_we)); // R5

  AST_NO_PORT_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_en && a_we) && !(b_en && b_we)); // R1
endmodule

// File: tb/tdm_regfile_tb.sv
module tdm_regfile_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int NR    = 5;
  localparam int NW    = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              tgt_strobe_i = 1'b0;
  logic [NW-1:0]     wr_en_i = '0;
  logic [NW*AW-1:0]  wr_addr_i = '0;
  logic [NW*DW-1:0]  wr_data_i = '0;
  logic [NR*AW-1:0]  rd_addr_i = '0;
  logic [NR*DW-1:0]  rd_data_o;

  always #4 clk_i = ~clk_i;

  tdm_regfile #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_strobe_i (tgt_strobe_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R5";
  bit check_en = 1'b1;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_out [NR];
  logic [DW-1:0] pend [NR];
  bit pend_v = 1'b0;
  int edge_cnt = 100;

  logic [NW-1:0] s_wen;
  logic [AW-1:0] s_wa [NW];
  logic [DW-1:0] s_wd [NW];
  logic [AW-1:0] s_ra [NR];

  task automatic check_out();
    for (int l = 0; l < NR; l++) begin
      n_chk++;
      if (rd_data_o[l*DW +: DW] !== exp_out[l]) begin
        n_bad++;
        $display("FAIL %s lane %0d got %h exp %h", cur_req, l,
                 rd_data_o[l*DW +: DW], exp_out[l]);
      end
    end
  endtask

  task automatic host_step(input bit stb);
    @(negedge clk_i);
    if (check_en) check_out();
    if (stb) begin
      wr_en_i = s_wen;
      for (int w = 0; w < NW; w++) begin
        wr_addr_i[w*AW +: AW] = s_wa[w];
        wr_data_i[w*DW +: DW] = s_wd[w];
      end
      for (int r = 0; r < NR; r++) rd_addr_i[r*AW +: AW] = s_ra[r];
    end else begin
      // garbage between strobes must be ignored (R6)
      wr_en_i   = NW'($urandom);
      wr_addr_i = (NW*AW)'({$urandom, $urandom});
      wr_data_i = (NW*DW)'({$urandom, $urandom});
      rd_addr_i = (NR*AW)'({$urandom, $urandom});
    end
    tgt_strobe_i = stb;
    @(posedge clk_i);
    edge_cnt++;
    if (edge_cnt == 4 && pend_v) begin
      for (int r = 0; r < NR; r++) exp_out[r] = pend[r];
      pend_v = 1'b0;
    end
    if (stb) begin
      for (int r = 0; r < NR; r++) pend[r] = model[s_ra[r]];
      for (int w = 0; w < NW; w++) if (s_wen[w]) model[s_wa[w]] = s_wd[w];
      pend_v = 1'b1;
      edge_cnt = 0;
    end
  endtask

  task automatic tcyc();
    host_step(1'b1);
    repeat (3) host_step(1'b0);
  endtask

  task automatic rand_stim();
    s_wen = NW'($urandom);
    for (int w = 0; w < NW; w++) begin
      s_wa[w] = AW'($urandom);
      s_wd[w] = DW'($urandom);
    end
    for (int r = 0; r < NR; r++) s_ra[r] = AW'($urandom);
  endtask

  task automatic reads_all(input logic [AW-1:0] a);
    for (int r = 0; r < NR; r++) s_ra[r] = a;
  endtask

  initial begin
    for (int r = 0; r < NR; r++) exp_out[r] = '0;
    // R5: reset state and idle before first strobe
    #1;
    check_out();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) host_step(1'b0);

    // fill all entries; output unknown here, so no compare
    check_en = 1'b0;
    for (int c = 0; c < 6; c++) begin
      s_wen = 3'b111;
      for (int w = 0; w < NW; w++) begin
        s_wa[w] = AW'(3*c + w);
        s_wd[w] = DW'($urandom);
      end
      reads_all('0);
      tcyc();
    end
    s_wen = '0;
    tcyc();
    tcyc();
    check_en = 1'b1;

    // R1: same-cycle write and read of one address returns old data
    cur_req = "R1";
    s_wen = 3'b001; s_wa[0] = 4'd3; s_wd[0] = 16'hA5A5;
    s_wa[1] = 4'd0; s_wa[2] = 4'd0; s_wd[1] = '0; s_wd[2] = '0;
    reads_all(4'd3);
    tcyc();
    // R7: next cycle sees the new value
    cur_req = "R7";
    s_wen = '0;
    reads_all(4'd3);
    tcyc();

    // R2: three ports on one address, port 2 wins
    cur_req = "R2";
    s_wen = 3'b111;
    for (int w = 0; w < NW; w++) begin
      s_wa[w] = 4'd5; s_wd[w] = DW'(16'h1110 + w);
    end
    reads_all(4'd5);
    tcyc();
    // R2: ports 0 and 1 only, port 1 wins
    s_wen = 3'b011;
    s_wa[0] = 4'd6; s_wd[0] = 16'h0600;
    s_wa[1] = 4'd6; s_wd[1] = 16'h0601;
    s_wa[2] = 4'd6; s_wd[2] = 16'hDEAD;
    reads_all(4'd5);
    tcyc();
    s_wen = '0;
    reads_all(4'd6);
    tcyc();

    // R3: disabled ports leave entries intact
    cur_req = "R3";
    s_wen = 3'b000;
    for (int w = 0; w < NW; w++) begin
      s_wa[w] = 4'd6; s_wd[w] = 16'hBEEF;
    end
    reads_all(4'd6);
    tcyc();
    tcyc();

    // R1: phase-2 case, lane 4 reads what write port 0 writes
    cur_req = "R1";
    s_wen = 3'b001; s_wa[0] = 4'd9; s_wd[0] = 16'h0909;
    reads_all(4'd9);
    tcyc();
    s_wen = '0;
    tcyc();

    // R8: distinct addresses per lane
    cur_req = "R8";
    for (int r = 0; r < NR; r++) s_ra[r] = AW'(r + 10);
    tcyc();
    tcyc();

    // R6/R4: long idle with garbage inputs, outputs hold
    cur_req = "R6";
    for (int i = 0; i < 20; i++) host_step(1'b0);
    s_wen = '0;
    reads_all(4'd5);
    tcyc();
    tcyc();

    // R7: random traffic
    cur_req = "R7";
    for (int c = 0; c < 300; c++) begin
      rand_stim();
      tcyc();
    end
    s_wen = '0;
    tcyc();
    for (int i = 0; i < 6; i++) host_step(1'b0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule